// File: doc/BRIEF.md
# Saturating Accumulator ALU

This block is the 32-bit accumulator datapath of a 16-bit fixed-point signal processor. On each operation strobe it takes one operation code and updates the accumulator. The operand can be a 16-bit memory word, shifted and optionally sign-extended, or the 32-bit product register value. The update is one of: add, subtract, load, bitwise logic, absolute value, or one conditional-subtract step of a long division.

Arithmetic results are checked for two's-complement overflow. An overflow sets a sticky overflow flag. If overflow mode is on, the accumulator also clamps to the largest positive or negative value, picked by the sign the accumulator had before the operation. Only the overflow-test operation clears the flag. The surrounding core provides the opcode, the operand, the shift amount and the product, and reads back the accumulator and the flag.

Top module: `sat_acc_alu`

## Requirements
- R1: After reset (rst_n low), the accumulator is 0 and the overflow flag is 0.
- R2: State changes only on a clock edge where op_valid is high, and the result appears on that edge. With op_valid low, or with code 0 (idle), the accumulator and the flag hold. Code 1 adds the operand shifted left by shift_amt (0 to 15) to the accumulator, and code 2 subtracts it. The operand is sign-extended when sign_ext is 1 and zero-extended when it is 0.
- R3: Codes 3 and 4 add and subtract the zero-extended operand shifted left by 16. Codes 5 and 6 add and subtract the zero-extended operand with no shift.
- R4: Code 7 adds the 32-bit product input to the accumulator, and code 8 subtracts it.
- R5: For the add codes (1, 3, 5, 7), overflow is two operands of equal sign giving a sum of the other sign. For the subtract codes (2, 4, 6, 8), overflow is operands of differing sign where the result's sign differs from the old accumulator. Overflow sets the flag. No arithmetic code ever clears it.
- R6: On overflow with ovf_mode at 1, the accumulator becomes 0x80000000 if the old accumulator was negative, and 0x7FFFFFFF otherwise. With ovf_mode at 0, the result wraps.
- R7: Code 15 (overflow test) clears the flag and leaves the accumulator unchanged.
- R8: Code 9 negates a negative accumulator and leaves a non-negative one unchanged. With ovf_mode at 1, a result of 0x80000000 becomes 0x7FFFFFFF. The flag is not affected.
- R9: Code 10 (division step) forms the accumulator minus the zero-extended operand shifted left by 15. If that difference is non-negative, the accumulator becomes the difference doubled plus 1. Otherwise the old accumulator is doubled. The flag is not affected.
- R10: Code 11 ANDs the accumulator with the zero-extended operand, which clears the upper half. Codes 12 and 13 OR and XOR the operand into the low 16 bits only.
- R11: Code 14 loads the accumulator with the operand shifted by shift_amt, extended as selected by sign_ext. The flag is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_sel | input | 4 | Operation code |
| operand | input | 16 | Memory operand |
| shift_amt | input | 4 | Left shift for codes 1, 2 and 14 |
| sign_ext | input | 1 | Sign-extend the operand for codes 1, 2 and 14 |
| product | input | 32 | Product register value |
| ovf_mode | input | 1 | Saturate on overflow when 1 |
| acc | output | 32 | Accumulator |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench sends both overflow directions into the most positive and most negative accumulator values. A design that saturated by the result's sign, rather than the old sign, would clamp to the wrong end. It also runs a subtraction of two equal-signed values that crosses zero: a design that reused the addition overflow rule would flag it and saturate by mistake. Further cases cover the flag staying set through a clean operation, the division step on both sides of zero, absolute value of the most negative number with overflow mode on and off, and OR/XOR leaving the upper half intact.

// File: rtl/sat_acc_pkg.sv
package sat_acc_pkg;

   typedef enum logic [3:0] {
      OP_IDLE     = 4'd0,
      OP_ADD_SH   = 4'd1,
      OP_SUB_SH   = 4'd2,
      OP_ADD_HI   = 4'd3,
      OP_SUB_HI   = 4'd4,
      OP_ADD_LO   = 4'd5,
      OP_SUB_LO   = 4'd6,
      OP_ADD_PROD = 4'd7,
      OP_SUB_PROD = 4'd8,
      OP_ABS      = 4'd9,
      OP_DIV_STEP = 4'd10,
      OP_AND      = 4'd11,
      OP_OR       = 4'd12,
      OP_XOR      = 4'd13,
      OP_LOAD_SH  = 4'd14,
      OP_TEST_OV  = 4'd15
   } acc_op_e;

   function automatic logic op_sets_ovf(acc_op_e op);
      return op inside {OP_ADD_SH, OP_SUB_SH, OP_ADD_HI, OP_SUB_HI,
                        OP_ADD_LO, OP_SUB_LO, OP_ADD_PROD, OP_SUB_PROD};
   endfunction

   function automatic logic op_subtracts(acc_op_e op);
      return op inside {OP_SUB_SH, OP_SUB_HI, OP_SUB_LO, OP_SUB_PROD, OP_DIV_STEP};
   endfunction

endpackage

// File: rtl/acc_operand_shift.sv
module acc_operand_shift #(
   parameter int DATA_W       = 16,
   parameter int ACC_W        = 32,
   parameter int SH_W         = 5,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   input  logic [SH_W-1:0]   sh,
   input  logic              sext,
   output logic [ACC_W-1:0]  y
);
   localparam int PAD_W = ACC_W - DATA_W;

   logic [ACC_W-1:0] ext;
   assign ext = {{PAD_W{sext & data[DATA_W-1]}}, data};

   generate
      if (SHIFT_STAGED) begin : g_staged
         logic [ACC_W-1:0] stg [0:SH_W];
         assign stg[0] = ext;
         for (genvar i = 0; i < SH_W; i++) begin : g_stage
            assign stg[i+1] = sh[i] ? (stg[i] << (1 << i)) : stg[i];
         end
         assign y = stg[SH_W];
      end else begin : g_flat
         assign y = ext << sh;
      end
   endgenerate
endmodule

// File: rtl/acc_addsub_sat.sv
module acc_addsub_sat #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic             sub,
   input  logic             ovm,
   output logic [ACC_W-1:0] raw,
   output logic [ACC_W-1:0] result,
   output logic             ovf
);
   localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

   logic [ACC_W-1:0] same_or_diff;
   always_comb begin
      raw          = sub ? (a - b) : (a + b);
      same_or_diff = sub ? (a ^ b) : ~(a ^ b);
      ovf          = same_or_diff[ACC_W-1] & (a[ACC_W-1] ^ raw[ACC_W-1]);
      if (ovf && ovm) result = a[ACC_W-1] ? NEG_MAX : POS_MAX;
      else            result = raw;
   end
endmodule

// File: rtl/acc_abs_unit.sv
module acc_abs_unit #(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] a,
   input  logic             ovm,
   output logic [ACC_W-1:0] y
);
   localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

   logic [ACC_W-1:0] neg;
   always_comb begin
      neg = -a;
      if (!a[ACC_W-1])                y = a;
      else if (ovm && neg == NEG_MAX) y = POS_MAX;
      else                            y = neg;
   end
endmodule

// File: rtl/sat_acc_alu.sv
module sat_acc_alu
   import sat_acc_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SHIFT_W      = 4,
   parameter int ACC_W        = 32,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] operand,
   input  logic [SHIFT_W-1:0] shift_amt,
   input  logic              sign_ext,
   input  logic [ACC_W-1:0]  product,
   input  logic              ovf_mode,
   output logic [ACC_W-1:0]  acc,
   output logic              ovf_flag
);
   localparam int SH_IN_W = SHIFT_W + 1;
   localparam logic [ACC_W-1:0] NEG_MAX = {1'b1, {(ACC_W-1){1'b0}}};

   generate
      if (ACC_W != 2 * DATA_W) begin : g_bad_acc
         $error("ACC_W must be twice DATA_W");
      end
      if ((1 << SHIFT_W) != DATA_W) begin : g_bad_shift
         $error("SHIFT_W must address every bit of DATA_W");
      end
   endgenerate

   acc_op_e op;
   assign op = acc_op_e'(op_sel);

   logic [ACC_W-1:0] acc_q;
   logic             ovf_q;

   // operand shift and extension choice
   logic [SH_IN_W-1:0] eff_sh;
   logic               eff_sext;
   always_comb begin
      eff_sh   = '0;
      eff_sext = 1'b0;
      unique case (op)
         OP_ADD_SH, OP_SUB_SH, OP_LOAD_SH: begin
            eff_sh   = {1'b0, shift_amt};
            eff_sext = sign_ext;
         end
         OP_ADD_HI, OP_SUB_HI: eff_sh = SH_IN_W'(DATA_W);
         OP_DIV_STEP:          eff_sh = SH_IN_W'(DATA_W - 1);
         default:              eff_sh = '0;
      endcase
   end

   logic [ACC_W-1:0] shifted;
   acc_operand_shift #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .SH_W(SH_IN_W), .SHIFT_STAGED(SHIFT_STAGED)
   ) u_shift (
      .data(operand), .sh(eff_sh), .sext(eff_sext), .y(shifted)
   );

   logic [ACC_W-1:0] addend, sum_raw, sum_sat, abs_val;
   logic             sum_ovf;
   assign addend = (op == OP_ADD_PROD || op == OP_SUB_PROD) ? product : shifted;

   acc_addsub_sat #(.ACC_W(ACC_W)) u_addsub (
      .a(acc_q), .b(addend), .sub(op_subtracts(op)), .ovm(ovf_mode),
      .raw(sum_raw), .result(sum_sat), .ovf(sum_ovf)
   );

   acc_abs_unit #(.ACC_W(ACC_W)) u_abs (
      .a(acc_q), .ovm(ovf_mode), .y(abs_val)
   );

   logic [ACC_W-1:0] zext_opnd;
   assign zext_opnd = {{(ACC_W-DATA_W){1'b0}}, operand};

   logic [ACC_W-1:0] acc_nxt;
   always_comb begin
      acc_nxt = acc_q;
      unique case (op)
         OP_ADD_SH, OP_SUB_SH, OP_ADD_HI, OP_SUB_HI,
         OP_ADD_LO, OP_SUB_LO, OP_ADD_PROD, OP_SUB_PROD: acc_nxt = sum_sat;
         OP_ABS:      acc_nxt = abs_val;
         OP_DIV_STEP: acc_nxt = sum_raw[ACC_W-1] ? (acc_q << 1)
                                                 : {sum_raw[ACC_W-2:0], 1'b1};
         OP_AND:      acc_nxt = acc_q & zext_opnd;
         OP_OR:       acc_nxt = {acc_q[ACC_W-1:DATA_W], acc_q[DATA_W-1:0] | operand};
         OP_XOR:      acc_nxt = {acc_q[ACC_W-1:DATA_W], acc_q[DATA_W-1:0] ^ operand};
         OP_LOAD_SH:  acc_nxt = shifted;
         default:     acc_nxt = acc_q;
      endcase
   end

   logic arith_ovf;
   assign arith_ovf = op_valid && op_sets_ovf(op) && sum_ovf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (op_valid) begin
         acc_q <= acc_nxt;
         if (op == OP_TEST_OV) ovf_q <= 1'b0;
         else if (arith_ovf)   ovf_q <= 1'b1;
      end
   end

   assign acc      = acc_q;
   assign ovf_flag = ovf_q;

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(acc) && $stable(ovf_flag)));

   assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !(op_valid && op_sel == OP_TEST_OV)) |=> ovf_flag);

   assert_ovf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(op_valid && op_sets_ovf(op)));

   assert_test_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_TEST_OV) |=> (!ovf_flag && $stable(acc)));

   assert_abs_no_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_ABS && ovf_mode) |=> (acc != NEG_MAX));
endmodule

// File: tb/sim_sat_acc_alu.sv
`timescale 1ns/1ps
module sim_sat_acc_alu;
   import sat_acc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_sel = 4'd0;
   logic [15:0] operand = '0;
   logic [3:0]  shift_amt = '0;
   logic        sign_ext = 1'b0;
   logic [31:0] product = '0;
   logic        ovf_mode = 1'b0;
   logic [31:0] acc;
   logic        ovf_flag;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   sat_acc_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .operand(operand), .shift_amt(shift_amt), .sign_ext(sign_ext),
      .product(product), .ovf_mode(ovf_mode), .acc(acc), .ovf_flag(ovf_flag)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic issue(acc_op_e op, logic [15:0] d, logic [3:0] sh, logic sx,
                        logic [31:0] p, logic ovm);
      @(negedge clk);
      op_sel = op; operand = d; shift_amt = sh; sign_ext = sx;
      product = p; ovf_mode = ovm; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic set_acc(logic [31:0] v);
      issue(OP_AND, 16'h0000, 4'd0, 1'b0, 32'h0, 1'b0);
      issue(OP_ADD_PROD, 16'h0000, 4'd0, 1'b0, v, 1'b0);
   endtask

   task automatic clear_ovf();
      issue(OP_TEST_OV, 16'h0, 4'd0, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic t_reset();
      check("R1 acc after reset", acc, 32'h0);
      check("R1 flag after reset", {31'b0, ovf_flag}, 32'h0);
   endtask

   task automatic t_shift_add();
      set_acc(32'h0000_0010);
      issue(OP_ADD_SH, 16'hFFFF, 4'd4, 1'b1, 32'h0, 1'b0);
      check("R2 add sign-extended shift 4", acc, 32'h0000_0000);
      issue(OP_ADD_SH, 16'h8001, 4'd15, 1'b0, 32'h0, 1'b0);
      check("R2 add zero-extended shift 15", acc, 32'h4000_8000);
      set_acc(32'h0);
      issue(OP_SUB_SH, 16'h0001, 4'd15, 1'b1, 32'h0, 1'b0);
      check("R2 sub shift 15", acc, 32'hFFFF_8000);
      // idle: strobe low while inputs toggle
      @(negedge clk);
      op_sel = OP_LOAD_SH; operand = 16'h1234; shift_amt = 4'd3;
      repeat (3) @(negedge clk);
      check("R2 hold without strobe", acc, 32'hFFFF_8000);
      issue(OP_IDLE, 16'h5555, 4'd2, 1'b1, 32'h1, 1'b1);
      check("R2 idle code holds", acc, 32'hFFFF_8000);
   endtask

   task automatic t_hi_lo();
      set_acc(32'h0001_0000);
      issue(OP_ADD_HI, 16'h8000, 4'd7, 1'b1, 32'h0, 1'b0);
      check("R3 add high", acc, 32'h8001_0000);
      check("R3 add high no overflow", {31'b0, ovf_flag}, 32'h0);
      set_acc(32'h0000_0005);
      issue(OP_SUB_LO, 16'hFFFF, 4'd9, 1'b1, 32'h0, 1'b0);
      check("R3 sub low zero-extended", acc, 32'hFFFF_0006);
      set_acc(32'h0003_0000);
      issue(OP_SUB_HI, 16'h0001, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R3 sub high", acc, 32'h0002_0000);
   endtask

   task automatic t_product();
      set_acc(32'h0000_0100);
      issue(OP_ADD_PROD, 16'h0, 4'd0, 1'b0, 32'h0000_0200, 1'b0);
      check("R4 add product", acc, 32'h0000_0300);
      issue(OP_SUB_PROD, 16'h0, 4'd0, 1'b0, 32'h0000_0400, 1'b0);
      check("R4 sub product", acc, 32'hFFFF_FF00);
   endtask

   task automatic t_overflow();
      set_acc(32'h7FFF_FFFF);
      issue(OP_ADD_LO, 16'h0001, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R6 wrap without mode", acc, 32'h8000_0000);
      check("R5 add overflow sets flag", {31'b0, ovf_flag}, 32'h1);
      issue(OP_ADD_LO, 16'h0001, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R5 flag sticky acc", acc, 32'h8000_0001);
      check("R5 flag sticky", {31'b0, ovf_flag}, 32'h1);
      clear_ovf();
      set_acc(32'h7FFF_FFFF);
      issue(OP_ADD_LO, 16'h0001, 4'd0, 1'b0, 32'h0, 1'b1);
      check("R6 saturate positive", acc, 32'h7FFF_FFFF);
      check("R5 flag on saturate", {31'b0, ovf_flag}, 32'h1);
      clear_ovf();
      set_acc(32'h8000_0000);
      issue(OP_SUB_LO, 16'h0001, 4'd0, 1'b0, 32'h0, 1'b1);
      check("R6 saturate negative on sub", acc, 32'h8000_0000);
      check("R5 sub overflow flag", {31'b0, ovf_flag}, 32'h1);
      clear_ovf();
      set_acc(32'h8000_0000);
      issue(OP_SUB_PROD, 16'h0, 4'd0, 1'b0, 32'h8000_0000, 1'b1);
      check("R5 same-sign sub no clamp", acc, 32'h0);
      check("R5 same-sign sub no flag", {31'b0, ovf_flag}, 32'h0);
      set_acc(32'h8000_0000);
      issue(OP_ADD_PROD, 16'h0, 4'd0, 1'b0, 32'hFFFF_FFFF, 1'b1);
      check("R6 saturate negative on add", acc, 32'h8000_0000);
      check("R5 negative add flag", {31'b0, ovf_flag}, 32'h1);
   endtask

   task automatic t_test_ovf();
      set_acc(32'h1234_5678);
      issue(OP_TEST_OV, 16'hFFFF, 4'd3, 1'b1, 32'h1, 1'b1);
      check("R7 test clears flag", {31'b0, ovf_flag}, 32'h0);
      check("R7 test keeps acc", acc, 32'h1234_5678);
      issue(OP_TEST_OV, 16'h0, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R7 test with clear flag", {31'b0, ovf_flag}, 32'h0);
   endtask

   task automatic t_abs();
      set_acc(32'hFFFF_FFFB);
      issue(OP_ABS, 16'h0, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R8 abs negative", acc, 32'h0000_0005);
      issue(OP_ABS, 16'h0, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R8 abs positive", acc, 32'h0000_0005);
      set_acc(32'h8000_0000);
      issue(OP_ABS, 16'h0, 4'd0, 1'b0, 32'h0, 1'b0);
      check("R8 abs min wraps", acc, 32'h8000_0000);
      issue(OP_ABS, 16'h0, 4'd0, 1'b0, 32'h0, 1'b1);
      check("R8 abs min saturates", acc, 32'h7FFF_FFFF);
      check("R8 abs leaves flag", {31'b0, ovf_flag}, 32'h0);
   endtask

   task automatic t_div_step();
      set_acc(32'h0000_0021);
      issue(OP_DIV_STEP, 16'h0005, 4'd0, 1'b0, 32'h0, 1'b1);
      check("R9 step negative difference", acc, 32'h0000_0042);
      set_acc(32'h0003_0000);
      issue(OP_DIV_STEP, 16'h0005, 4'd0, 1'b0, 32'h0, 1'b1);
      check("R9 step non-negative difference", acc, 32'h0001_0001);
      check("R9 step leaves flag", {31'b0, ovf_flag}, 32'h0);
   endtask

   task automatic t_logic();
      set_acc(32'hFFFF_1234);
      issue(OP_AND, 16'h0F0F, 4'd0, 1'b1, 32'h0, 1'b0);
      check("R10 and clears upper", acc, 32'h0000_0204);
      set_acc(32'hFFFF_1234);
      issue(OP_OR, 16'h00F0, 4'd0, 1'b1, 32'h0, 1'b0);
      check("R10 or low only", acc, 32'hFFFF_12F4);
      issue(OP_XOR, 16'hFFFF, 4'd0, 1'b1, 32'h0, 1'b0);
      check("R10 xor low only", acc, 32'hFFFF_ED0B);
   endtask

   task automatic t_load();
      issue(OP_LOAD_SH, 16'h8000, 4'd1, 1'b1, 32'h0, 1'b0);
      check("R11 load sign-extended", acc, 32'hFFFF_0000);
      issue(OP_LOAD_SH, 16'hFFFF, 4'd15, 1'b0, 32'h0, 1'b0);
      check("R11 load zero-extended", acc, 32'h7FFF_8000);
      check("R11 load leaves flag", {31'b0, ovf_flag}, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shift_add();
      t_hi_lo();
      t_product();
      t_overflow();
      t_test_ovf();
      t_abs();
      t_div_step();
      t_logic();
      t_load();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule